// File: doc/BRIEF.md
# Coalescing Store Buffer with Word Forwarding

This block sits between a processor core and its private cache and holds stores that the core has retired but the cache has not yet absorbed. Each slot holds one whole cache line. A new store either merges into the slot that already holds its line or takes a free slot. Each slot keeps a per-word written mask, so a later store to the same word overwrites the earlier value. A load presents a line and word address. If the buffer holds a written value for that word, the load takes it at once and never reaches the load buffer.

Slots leave the buffer towards the cache in any order. The drain machine has two states. `DR_IDLE` chooses the lowest-index slot that the companion load buffer does not block. It then moves to `DR_REQ` (transition *pick*). `DR_REQ` requests the line and waits for a grant, which tells it that the cache holds the line exclusive. In the grant cycle the cache writes the line and the slot is freed, and the machine returns to `DR_IDLE` (transition *commit*). If the load buffer blocks the chosen slot while the request is open, the request drops at once and the machine returns to `DR_IDLE` (transition *withdraw*). A fence stops new stores and reports done once every slot has drained.

Top module: `coalescing_store_buffer`

## Requirements
- R1: A store to a line already held merges into that slot. A store to a new line takes the lowest-index free slot. The slot table is visible on `hq_valid`/`hq_lines`, with slot i at bits [i*LINE_W +: LINE_W]. No two valid slots ever hold the same line.
- R2: When two stores to the same word are merged, the slot keeps the data of the later store.
- R3: A load with `ld_valid` high returns `ld_hit`=1 and the stored word only when a valid slot holds its line and that word was written. Otherwise `ld_hit`=0 and `ld_data`=0.
- R4: From `DR_IDLE`, the drain picks the lowest-index valid slot whose `hq_blocked` bit is 0. It does this regardless of the order in which the stores were issued.
- R5: `dr_req` is never high for a slot whose `hq_blocked` bit is 1. Raising that bit during `DR_REQ` drops `dr_req` in the same cycle.
- R6: `dr_req` stays high until `dr_grant`. While it is high, `dr_line`, `dr_mask` (bit w = word w written) and `dr_data` (word w at bits [w*DATA_W +: DATA_W]) show the slot. In the grant cycle the slot is freed, and it is gone after that edge.
- R7: When every slot is valid, a store to a line not held sees `st_ready`=0. A store to a held line is still accepted.
- R8: A store to the line that `dr_req` is currently presenting sees `st_ready`=0.
- R9: While `fence_req` is high, `st_ready` is 0. `fence_done` is high exactly when `fence_req` is high and no slot is valid.
- R10: After reset no slot is valid, `dr_req` is 0 and `st_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store offered |
| st_ready | output | 1 | Store accepted this cycle |
| st_line | input | LINE_W | Line address of store |
| st_word | input | log2(WORDS) | Word within line |
| st_data | input | DATA_W | Store data |
| ld_valid | input | 1 | Load probe valid |
| ld_line | input | LINE_W | Load line address |
| ld_word | input | log2(WORDS) | Load word within line |
| ld_hit | output | 1 | Word forwarded from buffer |
| ld_data | output | DATA_W | Forwarded data, 0 on miss |
| hq_valid | output | N_ENT | Slot valid flags for hazard query |
| hq_lines | output | N_ENT*LINE_W | Slot line addresses for hazard query |
| hq_blocked | input | N_ENT | Slot has an older pending load to its line |
| dr_req | output | 1 | Drain request for presented line |
| dr_line | output | LINE_W | Line being drained |
| dr_mask | output | WORDS | Written-word mask of drained line |
| dr_data | output | WORDS*DATA_W | Line data being drained |
| dr_grant | input | 1 | Line exclusive, cache writes now |
| fence_req | input | 1 | Fence pending |
| fence_done | output | 1 | Fence satisfied, buffer empty |

## Verification
On every cycle the assertions check the following: no line is held twice, no request is raised for a blocked line, a committed line is gone after the grant edge, stores are stalled under a fence or when the buffer is full, and fence done implies an empty table. The scenarios alone can show the data-level behaviour: later-store-wins merging, forwarding of written words only, the lowest-eligible drain choice, the out-of-order drain past a blocked slot, withdrawal of a request, and the stall on the line under drain. These are compared against a slot model kept in the bench.

// File: rtl/sb_pkg.sv
package sb_pkg;
    typedef enum logic [0:0] {
        DR_IDLE = 1'b0,
        DR_REQ  = 1'b1
    } drain_state_t;
endpackage

// File: rtl/sb_pick_low.sv
module sb_pick_low #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sb_entry.sv
module sb_entry #(
    parameter int LINE_W = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int WI = (WORDS > 1) ? $clog2(WORDS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic                    wr_alloc,
    input  logic [LINE_W-1:0]       wr_line,
    input  logic [WI-1:0]           wr_word,
    input  logic [DATA_W-1:0]       wr_data,
    input  logic                    clr,
    output logic                    valid,
    output logic [LINE_W-1:0]       line,
    output logic [WORDS-1:0]        mask,
    output logic [WORDS*DATA_W-1:0] data
);
    logic [WORDS-1:0] word_bit;

    assign word_bit = WORDS'(1) << wr_word;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid <= 1'b0;
            line  <= '0;
            mask  <= '0;
            data  <= '0;
        end else if (clr) begin
            valid <= 1'b0;
            mask  <= '0;
        end else if (wr_en) begin
            data[wr_word*DATA_W +: DATA_W] <= wr_data;
            if (wr_alloc) begin
                valid <= 1'b1;
                line  <= wr_line;
                mask  <= word_bit;
            end else begin
                mask  <= mask | word_bit;
            end
        end
    end
endmodule

// File: rtl/sb_drain_fsm.sv
module sb_drain_fsm
    import sb_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cand_any,
    input  logic [IW-1:0] cand_idx,
    input  logic          sel_blocked,
    input  logic          grant,
    output logic [IW-1:0] sel,
    output logic          req,
    output logic          fire
);
    drain_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= DR_IDLE;
            sel     <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == DR_IDLE && cand_any) begin
                sel <= cand_idx;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DR_IDLE: if (cand_any) state_d = DR_REQ;
            DR_REQ: begin
                if (fire || sel_blocked) state_d = DR_IDLE;
            end
            default: state_d = DR_IDLE;
        endcase
    end

    always_comb begin
        req  = 1'b0;
        fire = 1'b0;
        unique case (state_q)
            DR_IDLE: begin
                req  = 1'b0;
                fire = 1'b0;
            end
            DR_REQ: begin
                req  = !sel_blocked;
                fire = !sel_blocked && grant;
            end
            default: begin
                req  = 1'b0;
                fire = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/coalescing_store_buffer.sv
module coalescing_store_buffer #(
    parameter int N_ENT  = 4,
    parameter int LINE_W = 8,
    parameter int WORDS  = 4,
    parameter int DATA_W = 16,
    localparam int WI = (WORDS > 1) ? $clog2(WORDS) : 1,
    localparam int IW = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    st_valid,
    output logic                    st_ready,
    input  logic [LINE_W-1:0]       st_line,
    input  logic [WI-1:0]           st_word,
    input  logic [DATA_W-1:0]       st_data,
    input  logic                    ld_valid,
    input  logic [LINE_W-1:0]       ld_line,
    input  logic [WI-1:0]           ld_word,
    output logic                    ld_hit,
    output logic [DATA_W-1:0]       ld_data,
    output logic [N_ENT-1:0]        hq_valid,
    output logic [N_ENT*LINE_W-1:0] hq_lines,
    input  logic [N_ENT-1:0]        hq_blocked,
    output logic                    dr_req,
    output logic [LINE_W-1:0]       dr_line,
    output logic [WORDS-1:0]        dr_mask,
    output logic [WORDS*DATA_W-1:0] dr_data,
    input  logic                    dr_grant,
    input  logic                    fence_req,
    output logic                    fence_done
);
    logic [N_ENT-1:0]        valid_q;
    logic [LINE_W-1:0]       line_q [N_ENT];
    logic [WORDS-1:0]        mask_q [N_ENT];
    logic [WORDS*DATA_W-1:0] data_q [N_ENT];

    logic [N_ENT-1:0] st_match;
    logic [N_ENT-1:0] wr_en;
    logic [N_ENT-1:0] clr;
    logic             st_hit;
    logic             free_any;
    logic [IW-1:0]    free_idx;
    logic             cand_any;
    logic [IW-1:0]    cand_idx;
    logic [IW-1:0]    sel;
    logic             fire;
    logic             drain_clash;
    logic             st_fire;

    // slot storage
    for (genvar g = 0; g < N_ENT; g++) begin : g_slot
        sb_entry #(
            .LINE_W (LINE_W),
            .WORDS  (WORDS),
            .DATA_W (DATA_W)
        ) u_entry (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (wr_en[g]),
            .wr_alloc (!st_hit),
            .wr_line  (st_line),
            .wr_word  (st_word),
            .wr_data  (st_data),
            .clr      (clr[g]),
            .valid    (valid_q[g]),
            .line     (line_q[g]),
            .mask     (mask_q[g]),
            .data     (data_q[g])
        );
        assign st_match[g] = valid_q[g] && (line_q[g] == st_line);
        assign hq_valid[g] = valid_q[g];
        assign hq_lines[g*LINE_W +: LINE_W] = line_q[g];
        assign clr[g] = fire && (sel == IW'(g));
        assign wr_en[g] = st_fire && (st_hit ? st_match[g] : (free_idx == IW'(g)));
    end

    // free-slot choice for new lines
    sb_pick_low #(.N(N_ENT)) u_free_pick (
        .req (~valid_q),
        .any (free_any),
        .idx (free_idx)
    );

    // drain candidate choice
    sb_pick_low #(.N(N_ENT)) u_drain_pick (
        .req (valid_q & ~hq_blocked),
        .any (cand_any),
        .idx (cand_idx)
    );

    sb_drain_fsm #(.N(N_ENT)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .cand_any    (cand_any),
        .cand_idx    (cand_idx),
        .sel_blocked (hq_blocked[sel]),
        .grant       (dr_grant),
        .sel         (sel),
        .req         (dr_req),
        .fire        (fire)
    );

    assign st_hit      = |st_match;
    assign drain_clash = dr_req && st_match[sel];
    assign st_ready    = !fence_req && !drain_clash && (st_hit || free_any);
    assign st_fire     = st_valid && st_ready;

    assign dr_line = dr_req ? line_q[sel] : '0;
    assign dr_mask = dr_req ? mask_q[sel] : '0;
    assign dr_data = dr_req ? data_q[sel] : '0;

    assign fence_done = fence_req && (valid_q == '0);

    // word forwarding to loads
    always_comb begin
        ld_hit  = 1'b0;
        ld_data = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (ld_valid && valid_q[i] && (line_q[i] == ld_line) && mask_q[i][ld_word]) begin
                ld_hit  = 1'b1;
                ld_data = data_q[i][ld_word*DATA_W +: DATA_W];
            end
        end
    end
endmodule

// File: rtl/sb_checker.sv
module sb_checker #(
    parameter int N_ENT  = 4,
    parameter int LINE_W = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    st_valid,
    input logic                    st_ready,
    input logic [LINE_W-1:0]       st_line,
    input logic [N_ENT-1:0]        hq_valid,
    input logic [N_ENT*LINE_W-1:0] hq_lines,
    input logic [N_ENT-1:0]        hq_blocked,
    input logic                    dr_req,
    input logic                    dr_grant,
    input logic [LINE_W-1:0]       dr_line,
    input logic                    fence_req,
    input logic                    fence_done
);
    logic              dup;
    logic              req_on_blocked;
    logic              line_present;
    logic              still_held;
    logic              prev_fire;
    logic [LINE_W-1:0] prev_line;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_fire <= 1'b0;
            prev_line <= '0;
        end else begin
            prev_fire <= dr_req && dr_grant;
            prev_line <= dr_line;
        end
    end

    always_comb begin
        dup            = 1'b0;
        req_on_blocked = 1'b0;
        line_present   = 1'b0;
        still_held     = 1'b0;
        for (int i = 0; i < N_ENT; i++) begin
            if (hq_valid[i] && hq_blocked[i] && hq_lines[i*LINE_W +: LINE_W] == dr_line)
                req_on_blocked = 1'b1;
            if (hq_valid[i] && hq_lines[i*LINE_W +: LINE_W] == st_line)
                line_present = 1'b1;
            if (hq_valid[i] && hq_lines[i*LINE_W +: LINE_W] == prev_line)
                still_held = 1'b1;
            for (int j = i + 1; j < N_ENT; j++) begin
                if (hq_valid[i] && hq_valid[j] &&
                    hq_lines[i*LINE_W +: LINE_W] == hq_lines[j*LINE_W +: LINE_W])
                    dup = 1'b1;
            end
        end
    end

    a_r1_unique_line: assert property (@(posedge clk) disable iff (!rst_n) !dup);
    a_r5_no_blocked_req: assert property (@(posedge clk) disable iff (!rst_n)
        dr_req |-> !req_on_blocked);
    a_r6_commit_frees: assert property (@(posedge clk) disable iff (!rst_n)
        prev_fire |-> !still_held);
    a_r7_full_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (st_valid && (&hq_valid) && !line_present) |-> !st_ready);
    a_r9_fence_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        fence_req |-> !st_ready);
    a_r9_done_empty: assert property (@(posedge clk) disable iff (!rst_n)
        fence_done |-> (hq_valid == '0));
endmodule

bind coalescing_store_buffer sb_checker #(
    .N_ENT  (N_ENT),
    .LINE_W (LINE_W)
) u_sb_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .st_valid   (st_valid),
    .st_ready   (st_ready),
    .st_line    (st_line),
    .hq_valid   (hq_valid),
    .hq_lines   (hq_lines),
    .hq_blocked (hq_blocked),
    .dr_req     (dr_req),
    .dr_grant   (dr_grant),
    .dr_line    (dr_line),
    .fence_req  (fence_req),
    .fence_done (fence_done)
);

// File: tb/test_coalescing_store_buffer.sv
module test_coalescing_store_buffer;
    localparam int N  = 4;
    localparam int LW = 8;
    localparam int W  = 4;
    localparam int DW = 16;
    localparam int WI = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0;
    logic st_ready;
    logic [LW-1:0] st_line = '0;
    logic [WI-1:0] st_word = '0;
    logic [DW-1:0] st_data = '0;
    logic ld_valid = 1'b0;
    logic [LW-1:0] ld_line = '0;
    logic [WI-1:0] ld_word = '0;
    logic ld_hit;
    logic [DW-1:0] ld_data;
    logic [N-1:0] hq_valid;
    logic [N*LW-1:0] hq_lines;
    logic [N-1:0] hq_blocked = '1;
    logic dr_req;
    logic [LW-1:0] dr_line;
    logic [W-1:0] dr_mask;
    logic [W*DW-1:0] dr_data;
    logic dr_grant = 1'b0;
    logic fence_req = 1'b0;
    logic fence_done;

    always #4 clk = ~clk;

    coalescing_store_buffer #(.N_ENT(N), .LINE_W(LW), .WORDS(W), .DATA_W(DW)) i_coalescing_store_buffer (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
        .st_line(st_line), .st_word(st_word), .st_data(st_data),
        .ld_valid(ld_valid), .ld_line(ld_line), .ld_word(ld_word),
        .ld_hit(ld_hit), .ld_data(ld_data), .hq_valid(hq_valid),
        .hq_lines(hq_lines), .hq_blocked(hq_blocked), .dr_req(dr_req),
        .dr_line(dr_line), .dr_mask(dr_mask), .dr_data(dr_data),
        .dr_grant(dr_grant), .fence_req(fence_req), .fence_done(fence_done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic          m_v    [N];
    logic [LW-1:0] m_line [N];
    logic [W-1:0]  m_mask [N];
    logic [DW-1:0] m_data [N][W];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    function automatic bit exp_ready(input logic [LW-1:0] line);
        int nfree = 0;
        if (fence_req) return 0;
        for (int i = 0; i < N; i++) begin
            if (m_v[i] && m_line[i] == line) return !(dr_req && dr_line == line);
            if (!m_v[i]) nfree++;
        end
        return nfree > 0;
    endfunction

    function automatic int pick_exp(input logic [N-1:0] blk);
        for (int i = 0; i < N; i++) if (m_v[i] && !blk[i]) return i;
        return -1;
    endfunction

    task automatic check_table(input string req);
        for (int i = 0; i < N; i++) begin
            chk(hq_valid[i] == m_v[i], req, hq_valid[i], m_v[i]);
            if (m_v[i]) chk(hq_lines[i*LW +: LW] == m_line[i], req, hq_lines[i*LW +: LW], m_line[i]);
        end
    endtask

    task automatic do_store(input logic [LW-1:0] line, input logic [WI-1:0] word,
                            input logic [DW-1:0] data, input string req);
        bit er;
        @(negedge clk);
        st_valid = 1; st_line = line; st_word = word; st_data = data;
        #1;
        er = exp_ready(line);
        chk(st_ready == er, req, st_ready, er);
        @(posedge clk);
        if (er) begin
            int slot = -1;
            for (int i = 0; i < N; i++) if (m_v[i] && m_line[i] == line) slot = i;
            if (slot < 0) begin
                for (int i = N - 1; i >= 0; i--) if (!m_v[i]) slot = i;
                m_v[slot] = 1; m_line[slot] = line; m_mask[slot] = '0;
            end
            m_mask[slot][word] = 1'b1;
            m_data[slot][word] = data;
        end
        #1 st_valid = 0;
    endtask

    task automatic do_load(input logic [LW-1:0] line, input logic [WI-1:0] word, input string req);
        bit eh = 0;
        logic [DW-1:0] ed = '0;
        @(negedge clk);
        ld_valid = 1; ld_line = line; ld_word = word;
        #1;
        for (int i = 0; i < N; i++)
            if (m_v[i] && m_line[i] == line && m_mask[i][word]) begin eh = 1; ed = m_data[i][word]; end
        chk(ld_hit == eh, req, ld_hit, eh);
        chk(ld_data == ed, req, ld_data, ed);
        ld_valid = 0;
    endtask

    // unblock per blk and wait for the request; returns expected slot
    task automatic wait_req(input logic [N-1:0] blk, output int e);
        bit got = 0;
        e = pick_exp(blk);
        @(negedge clk);
        hq_blocked = blk;
        for (int k = 0; k < 4 && !got; k++) begin
            @(negedge clk); #1;
            if (dr_req) got = 1;
        end
        chk(got == (e >= 0), "R6 request raised", got, e >= 0);
        if (got && e >= 0) begin
            chk(dr_line == m_line[e], "R4 lowest eligible line", dr_line, m_line[e]);
            chk(dr_mask == m_mask[e], "R6 mask", dr_mask, m_mask[e]);
            for (int w = 0; w < W; w++)
                if (m_mask[e][w]) chk(dr_data[w*DW +: DW] == m_data[e][w], "R6 data", dr_data[w*DW +: DW], m_data[e][w]);
        end
    endtask

    task automatic grant_now(input int e);
        @(negedge clk);
        chk(dr_req == 1'b1, "R6 request held until grant", dr_req, 1);
        dr_grant = 1;
        @(posedge clk);
        #1 dr_grant = 0;
        m_v[e] = 0;
        @(negedge clk);
        hq_blocked = '1;
        repeat (2) @(negedge clk);
        check_table("R6 slot freed");
    endtask

    task automatic drain_one(input logic [N-1:0] blk);
        int e;
        wait_req(blk, e);
        if (e >= 0) grant_now(e);
        else begin
            @(negedge clk); hq_blocked = '1; repeat (2) @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        report();
    end

    initial begin
        int e;
        void'($urandom(32'h5EED));
        for (int i = 0; i < N; i++) begin m_v[i] = 0; m_line[i] = 0; m_mask[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        chk(st_ready == 1, "R10 ready", st_ready, 1);
        chk(hq_valid == '0, "R10 empty", hq_valid, 0);
        chk(dr_req == 0, "R10 no request", dr_req, 0);

        // R1/R2/R3 merge and forwarding
        do_store(8'h15, 1, 16'hAAAA, "R1 store");
        do_store(8'h15, 1, 16'hBBBB, "R2 later store");
        do_store(8'h15, 3, 16'h3333, "R1 merge");
        @(negedge clk); check_table("R1 single slot");
        do_load(8'h15, 1, "R2 later wins");
        do_load(8'h15, 2, "R3 unwritten word");
        do_load(8'h16, 1, "R3 absent line");

        // R7 full
        do_store(8'h20, 0, 16'h0020, "R1 alloc");
        do_store(8'h30, 2, 16'h0030, "R1 alloc");
        do_store(8'h40, 3, 16'h0040, "R1 alloc");
        do_store(8'h50, 0, 16'h0050, "R7 full new line stalls");
        do_store(8'h30, 1, 16'h1130, "R7 full merge accepted");
        @(negedge clk); check_table("R7 table");

        // R4/R5 out of order past a blocked slot
        drain_one(4'b1101);
        @(negedge clk); check_table("R4 table");
        // R5 withdrawal: request slot 0 then block it
        wait_req(4'b0000, e);
        @(negedge clk); hq_blocked = 4'b0001; #1;
        chk(dr_req == 0, "R5 withdraw on block", dr_req, 0);
        @(negedge clk); hq_blocked = '1; repeat (2) @(negedge clk);
        // R8 store to line under drain
        wait_req(4'b1011, e);
        do_store(m_line[e], 0, 16'h7777, "R8 clash stalls");
        grant_now(e);
        do_store(8'h60, 2, 16'h6060, "R1 reuse freed slot");
        @(negedge clk); check_table("R1 lowest free");

        // R9 fence
        @(negedge clk) fence_req = 1; #1;
        chk(st_ready == 0, "R9 fence stalls", st_ready, 0);
        chk(fence_done == 0, "R9 not done while held", fence_done, 0);
        for (int k = 0; k < N; k++) drain_one('0);
        @(negedge clk); #1;
        chk(fence_done == 1, "R9 done when empty", fence_done, 1);
        fence_req = 0;

        // constrained random mix
        for (int it = 0; it < 400; it++) begin
            int op = $urandom % 10;
            if (op < 5) do_store(LW'($urandom % 6), WI'($urandom % 4), DW'($urandom), "R2 random store");
            else if (op < 8) do_load(LW'($urandom % 6), WI'($urandom % 4), "R3 random load");
            else drain_one(N'($urandom));
        end
        @(negedge clk); check_table("R1 final table");
        report();
    end
endmodule